// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out a vector configuration request for a vector-capable core. Each request brings an application vector length (the number of elements software would like to process) and a proposed vector type word. The unit decodes the type word, decides whether it is legal for the configured hardware, works out the largest element count that one register group can hold for the chosen element width and grouping factor, and then updates the architectural length, type and start-index registers. The granted length goes back to the scalar side as a response one pipeline latency after the request.

Illegal type words are not clamped into something usable. Any of several independent faults collapses the architectural state to a type word that carries only the illegal flag, with zero length. Vector register width, largest element width and scalar word width are elaboration parameters. An optional register stage between decode and commit trades one cycle of latency for a shorter combinational path.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vtype_o holds only the illegal flag (bit XLEN-1 set, every other bit 0), vl_o is 0, vstart_o is 0 and rsp_valid is low.
- R2: The element-width code in type bits [4:2] selects a width of 8 << code bits, so codes 0, 1, 2, 3 give 8, 16, 32, 64. A code whose width is above ELEN (with the defaults, codes 4 to 7) makes the request illegal.
- R3: A request is illegal when the type word has the illegal flag (bit XLEN-1) set, a nonzero element-divide field (bits [6:5]), or any nonzero reserved bit (bits 7 to XLEN-2). Each of these causes is enough by itself.
- R4: An illegal request writes vtype_o with only bit XLEN-1 set, clears vl_o and vstart_o, and returns 0 on rsp_vl.
- R5: For a legal request the maximum length is VLEN * 2^g / SEW, where g is the grouping code in type bits [1:0] (codes 0 to 3 give factors 1, 2, 4, 8).
- R6: The granted length is the requested length when that is less than or equal to the maximum, and the maximum otherwise. The requested length is an unsigned XLEN-bit value, so zero is granted as zero and an all-ones request is granted the maximum.
- R7: A legal request copies the proposed type word unchanged into vtype_o, writes the granted length into vl_o, clears vstart_o, and returns the granted length on rsp_vl.
- R8: rsp_valid pulses for one cycle per request, 1 + PIPE_STAGE cycles after the cycle in which req_valid was high. Requests may be issued on back-to-back cycles and are answered in order. While rsp_valid is high, rsp_vl equals vl_o.
- R9: Without a request, vl_o, vtype_o and vstart_o keep their values whatever req_avl and req_vtype carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe |
| req_avl | input | XLEN | Requested application vector length, unsigned |
| req_vtype | input | XLEN | Proposed vector type word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_vl | output | XLEN | Granted length returned to the scalar destination |
| vl_o | output | XLEN | Architectural vector length register |
| vtype_o | output | XLEN | Architectural vector type register |
| vstart_o | output | XLEN | Architectural start-index register |

## Verification
The checker assumes that req_valid is a clean one-cycle strobe sampled at the clock edge and that req_avl and req_vtype are stable whenever it is high. It also assumes that the architectural registers change only through this unit, so any change with no response in flight is an error. The stimulus drives every input on the falling edge, holds the strobe for exactly one cycle, and sets the type words field by field, including each illegal cause on its own. Between requests the stimulus puts arbitrary values on the data inputs with the strobe low, so the hold property is tested against inputs that change.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   // Field positions inside the type word; the reserved range and the
   // illegal flag depend on XLEN and are derived in the modules.
   localparam int unsigned GRP_LSB  = 0;
   localparam int unsigned GRP_W    = 2;
   localparam int unsigned EW_LSB   = 2;
   localparam int unsigned EW_W     = 3;
   localparam int unsigned DIV_LSB  = 5;
   localparam int unsigned DIV_W    = 2;
   localparam int unsigned RSV_LSB  = 7;

   // Smallest element width is 2^3 bits.
   localparam int unsigned EW_BASE_LOG = 3;

   // Individual causes that make a type word illegal.
   typedef enum int unsigned {
      CAUSE_WIDTH   = 0,
      CAUSE_FLAG    = 1,
      CAUSE_DIVIDE  = 2,
      CAUSE_RESERVE = 3
   } cause_e;
   localparam int unsigned N_CAUSES = 4;

   // Commit action selected for a decoded request.
   typedef enum logic {
      ACT_ACCEPT   = 1'b0,
      ACT_COLLAPSE = 1'b1
   } act_e;

   // The largest legal element-width code for a given ELEN.
   function automatic int unsigned max_ew_code(input int unsigned elen);
      return $clog2(elen) - EW_BASE_LOG;
   endfunction

endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
   import vcfg_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned ELEN = 64
) (
   input  logic [XLEN-1:0]  vtype_i,
   output logic [GRP_W-1:0] grp_o,
   output logic [EW_W-1:0]  ew_o,
   output act_e             act_o
);
   localparam int unsigned FLAG_BIT = XLEN - 1;
   localparam int unsigned RSV_W    = XLEN - 1 - RSV_LSB;
   localparam int unsigned EW_MAX   = max_ew_code(ELEN);

   logic [DIV_W-1:0]    div_fld;
   logic [RSV_W-1:0]    rsv_fld;
   logic [N_CAUSES-1:0] cause;

   assign grp_o   = vtype_i[GRP_LSB +: GRP_W];
   assign ew_o    = vtype_i[EW_LSB  +: EW_W];
   assign div_fld = vtype_i[DIV_LSB +: DIV_W];
   assign rsv_fld = vtype_i[RSV_LSB +: RSV_W];

   // One detector per illegal cause; the final verdict is their OR.
   for (genvar c = 0; c < N_CAUSES; c++) begin : g_cause
      if (c == CAUSE_WIDTH) begin : g_w
         assign cause[c] = (32'(ew_o) > EW_MAX);
      end else if (c == CAUSE_FLAG) begin : g_f
         assign cause[c] = vtype_i[FLAG_BIT];
      end else if (c == CAUSE_DIVIDE) begin : g_d
         assign cause[c] = |div_fld;
      end else begin : g_r
         assign cause[c] = |rsv_fld;
      end
   end

   assign act_o = (|cause) ? ACT_COLLAPSE : ACT_ACCEPT;

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
   import vcfg_pkg::*;
#(
   parameter int unsigned VLEN = 128,
   localparam int unsigned VLW = $clog2(VLEN) + 1
) (
   input  logic [GRP_W-1:0] grp_i,
   input  logic [EW_W-1:0]  ew_i,
   output logic [VLW-1:0]   vlmax_o
);
   localparam int unsigned LOG_VLEN = $clog2(VLEN);
   localparam int unsigned EXP_W    = 8;

   logic [EXP_W-1:0] num_log;
   logic [EXP_W-1:0] den_log;
   logic [EXP_W-1:0] exp_v;
   logic             exp_ok;

   // All quantities are powers of two, so the quotient is 2^(num-den).
   assign num_log = EXP_W'(LOG_VLEN) + EXP_W'(grp_i);
   assign den_log = EXP_W'(EW_BASE_LOG) + EXP_W'(ew_i);
   assign exp_ok  = (num_log >= den_log);
   assign exp_v   = num_log - den_log;

   // One-hot decode of the exponent into the length.
   for (genvar k = 0; k < VLW; k++) begin : g_bit
      assign vlmax_o[k] = exp_ok && (exp_v == EXP_W'(k));
   end

endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned VLW  = 8
) (
   input  logic [XLEN-1:0] avl_i,
   input  logic [VLW-1:0]  vlmax_i,
   output logic [XLEN-1:0] grant_o
);
   logic [XLEN-1:0] cap;

   assign cap     = XLEN'(vlmax_i);
   assign grant_o = (avl_i <= cap) ? avl_i : cap;

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned VLEN       = 128,
   parameter int unsigned ELEN       = 64,
   parameter bit          PIPE_STAGE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [XLEN-1:0] req_avl,
   input  logic [XLEN-1:0] req_vtype,
   output logic            rsp_valid,
   output logic [XLEN-1:0] rsp_vl,
   output logic [XLEN-1:0] vl_o,
   output logic [XLEN-1:0] vtype_o,
   output logic [XLEN-1:0] vstart_o
);
   localparam int unsigned    VLW      = $clog2(VLEN) + 1;
   localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

   initial begin
      if (XLEN < 16)
         $error("vcfg_unit: XLEN must be at least 16");
      if ((VLEN & (VLEN - 1)) != 0 || (ELEN & (ELEN - 1)) != 0)
         $error("vcfg_unit: VLEN and ELEN must be powers of two");
      if (ELEN < 8 || ELEN > 64)
         $error("vcfg_unit: ELEN must lie between 8 and 64");
      if (VLEN < ELEN)
         $error("vcfg_unit: VLEN must not be below ELEN");
      if (VLW > XLEN)
         $error("vcfg_unit: VLEN too large for XLEN");
   end

   // ---------------- decode ----------------
   logic [GRP_W-1:0] d_grp;
   logic [EW_W-1:0]  d_ew;
   act_e             d_act;
   logic [VLW-1:0]   d_vlmax;
   logic [XLEN-1:0]  d_grant;

   vcfg_type_check #(.XLEN(XLEN), .ELEN(ELEN)) u_check (
      .vtype_i (req_vtype),
      .grp_o   (d_grp),
      .ew_o    (d_ew),
      .act_o   (d_act)
   );

   vcfg_vlmax #(.VLEN(VLEN)) u_vlmax (
      .grp_i   (d_grp),
      .ew_i    (d_ew),
      .vlmax_o (d_vlmax)
   );

   vcfg_grant #(.XLEN(XLEN), .VLW(VLW)) u_grant (
      .avl_i   (req_avl),
      .vlmax_i (d_vlmax),
      .grant_o (d_grant)
   );

   // ---------------- optional stage ----------------
   logic            c_valid;
   act_e            c_act;
   logic [XLEN-1:0] c_grant;
   logic [XLEN-1:0] c_vtype;

   if (PIPE_STAGE) begin : g_pipe
      logic            p_valid;
      act_e            p_act;
      logic [XLEN-1:0] p_grant;
      logic [XLEN-1:0] p_vtype;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_valid <= 1'b0;
            p_act   <= ACT_COLLAPSE;
            p_grant <= '0;
            p_vtype <= '0;
         end else begin
            p_valid <= req_valid;
            if (req_valid) begin
               p_act   <= d_act;
               p_grant <= d_grant;
               p_vtype <= req_vtype;
            end
         end
      end

      assign c_valid = p_valid;
      assign c_act   = p_act;
      assign c_grant = p_grant;
      assign c_vtype = p_vtype;
   end else begin : g_flow
      assign c_valid = req_valid;
      assign c_act   = d_act;
      assign c_grant = d_grant;
      assign c_vtype = req_vtype;
   end

   // ---------------- commit ----------------
   logic [XLEN-1:0] nx_vl;
   logic [XLEN-1:0] nx_vtype;

   always_comb begin
      if (c_act == ACT_COLLAPSE) begin
         nx_vl    = '0;
         nx_vtype = ILL_ONLY;
      end else begin
         nx_vl    = c_grant;
         nx_vtype = c_vtype;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtype_o   <= ILL_ONLY;
         vl_o      <= '0;
         vstart_o  <= '0;
         rsp_vl    <= '0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= c_valid;
         if (c_valid) begin
            vtype_o  <= nx_vtype;
            vl_o     <= nx_vl;
            vstart_o <= '0;
            rsp_vl   <= nx_vl;
         end
      end
   end

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned VLEN       = 128,
   parameter int unsigned ELEN       = 64,
   parameter bit          PIPE_STAGE = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            rsp_valid,
   input logic [XLEN-1:0] rsp_vl,
   input logic [XLEN-1:0] vl_o,
   input logic [XLEN-1:0] vtype_o,
   input logic [XLEN-1:0] vstart_o
);
   localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};
   localparam int unsigned     EW_MAX   = $clog2(ELEN) - 3;

   logic [1:0] req_hist;
   logic       rsp_due;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_hist <= '0;
      else        req_hist <= {req_hist[0], req_valid};
   end
   assign rsp_due = PIPE_STAGE ? req_hist[1] : req_hist[0];

   // R8
   rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == rsp_due);

   // R8
   rsp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_vl == vl_o));

   // R4
   collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && vtype_o[XLEN-1]) |-> (vtype_o == ILL_ONLY && vl_o == '0));

   // R3
   legal_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !vtype_o[XLEN-1]) |->
         (vtype_o[6:5] == 2'b00 && vtype_o[XLEN-2:7] == '0 && 32'(vtype_o[4:2]) <= EW_MAX));

   // R5
   vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (vl_o <= XLEN'(VLEN)));

   // R7
   vstart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (vstart_o == '0));

   // R9
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> ($stable(vl_o) && $stable(vtype_o) && $stable(vstart_o)));

endmodule

bind vcfg_unit vcfg_unit_chk #(
   .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .PIPE_STAGE(PIPE_STAGE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .rsp_valid (rsp_valid),
   .rsp_vl    (rsp_vl),
   .vl_o      (vl_o),
   .vtype_o   (vtype_o),
   .vstart_o  (vstart_o)
);

// File: tb/tb_vcfg_unit.sv
module tb_vcfg_unit;
   localparam int unsigned XLEN = 32;
   localparam int unsigned VLEN = 128;
   localparam int unsigned ELEN = 64;
   localparam logic [XLEN-1:0] ILL_ONLY = 32'h8000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [XLEN-1:0] req_avl = '0;
   logic [XLEN-1:0] req_vtype = '0;
   logic            rsp_valid;
   logic [XLEN-1:0] rsp_vl;
   logic [XLEN-1:0] vl_o;
   logic [XLEN-1:0] vtype_o;
   logic [XLEN-1:0] vstart_o;

   always #4 clk = ~clk;   // 125 MHz

   vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut (
      .clk, .rst_n, .req_valid, .req_avl, .req_vtype,
      .rsp_valid, .rsp_vl, .vl_o, .vtype_o, .vstart_o
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [XLEN-1:0] vl;
      logic [XLEN-1:0] vtype;
      string           tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [XLEN-1:0] mk(input int grp, input int ew, input int div);
      return XLEN'(grp) | (XLEN'(ew) << 2) | (XLEN'(div) << 5);
   endfunction

   // Reference model written from the requirements.
   function automatic exp_t model(input logic [XLEN-1:0] avl,
                                  input logic [XLEN-1:0] vt, input string tag);
      exp_t e;
      int unsigned ew_bits, vmax;
      bit ill;
      ew_bits = 8 << vt[4:2];
      ill = vt[31] || (vt[6:5] != 0) || (vt[30:7] != 0) || (ew_bits > ELEN);
      e.tag = tag;
      if (ill) begin
         e.vl = '0;
         e.vtype = ILL_ONLY;
      end else begin
         vmax = (VLEN * (1 << vt[1:0])) / ew_bits;
         e.vl = (avl <= XLEN'(vmax)) ? avl : XLEN'(vmax);
         e.vtype = vt;
      end
      return e;
   endfunction

   // Driver: one-cycle strobe, expectation pushed to the scoreboard.
   task automatic issue(input logic [XLEN-1:0] avl, input logic [XLEN-1:0] vt,
                        input string tag);
      sb.push_back(model(avl, vt, tag));
      req_avl   = avl;
      req_vtype = vt;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_avl   = 32'hDEAD_BEEF;
      req_vtype = 32'h7FFF_FFFF;
   endtask

   // Monitor: every response pops one expectation (R8 ordering).
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8", "unexpected response", rsp_vl, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_vl == e.vl,    e.tag, "rsp_vl",   rsp_vl,   e.vl);
            check(vl_o == e.vl,      e.tag, "vl_o",     vl_o,     e.vl);
            check(vtype_o == e.vtype, e.tag, "vtype_o", vtype_o,  e.vtype);
            check(vstart_o == '0,    e.tag, "vstart_o", vstart_o, '0);
         end
      end
   end

   // Watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [XLEN-1:0] keep_vl, keep_vt;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(vtype_o == ILL_ONLY, "R1", "vtype_o", vtype_o, ILL_ONLY);
      check(vl_o == '0,          "R1", "vl_o",    vl_o,    '0);
      check(vstart_o == '0,      "R1", "vstart_o", vstart_o, '0);
      check({31'd0, rsp_valid} == '0, "R1", "rsp_valid", {31'd0, rsp_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5/R6/R7: legal requests, 8-bit elements, factor 1 -> max 16
      issue(32'd5,          mk(0, 0, 0), "R7");
      issue(32'd16,         mk(0, 0, 0), "R6");
      issue(32'd17,         mk(0, 0, 0), "R6");
      issue(32'd0,          mk(0, 0, 0), "R6");
      issue(32'hFFFF_FFFF,  mk(0, 0, 0), "R6");
      // R5: other widths and groupings
      issue(32'd100,        mk(3, 2, 0), "R5");
      issue(32'd3,          mk(0, 3, 0), "R5");
      issue(32'd31,         mk(2, 1, 0), "R5");
      issue(32'd1000,       mk(3, 0, 0), "R5");
      issue(32'd2,          mk(1, 3, 0), "R2");
      // R2: width code above ELEN
      issue(32'd4,          mk(0, 4, 0), "R2");
      issue(32'd4,          mk(1, 7, 0), "R2");
      // R3/R4: each illegal cause alone
      issue(32'd4,          mk(0, 0, 0) | 32'h8000_0000, "R3");
      issue(32'd4,          mk(0, 1, 1), "R3");
      issue(32'd4,          mk(0, 1, 2), "R3");
      issue(32'd4,          mk(0, 1, 0) | 32'h0000_0080, "R4");
      issue(32'd4,          mk(0, 1, 0) | 32'h4000_0000, "R4");
      // legal after illegal: state recovers
      issue(32'd9,          mk(1, 1, 0), "R7");

      // R9: idle cycles with moving data inputs
      @(negedge clk);
      keep_vl = vl_o;
      keep_vt = vtype_o;
      for (int i = 0; i < 6; i++) begin
         req_avl   = 32'h1 << i;
         req_vtype = 32'h8000_0040 >> i;
         @(negedge clk);
         check(vl_o == keep_vl,    "R9", "vl_o held",    vl_o,    keep_vl);
         check(vtype_o == keep_vt, "R9", "vtype_o held", vtype_o, keep_vt);
         check({31'd0, rsp_valid} == '0, "R9", "no response", {31'd0, rsp_valid}, '0);
      end

      // R8: single response timing after an isolated request
      sb.push_back(model(32'd7, mk(0, 2, 0), "R8"));
      req_avl = 32'd7; req_vtype = mk(0, 2, 0); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check({31'd0, rsp_valid} == 32'd1, "R8", "rsp_valid after 1 cycle",
            {31'd0, rsp_valid}, 32'd1);
      @(negedge clk);
      check({31'd0, rsp_valid} == '0, "R8", "rsp_valid single pulse",
            {31'd0, rsp_valid}, '0);

      repeat (4) @(negedge clk);
      check(XLEN'(sb.size()) == '0, "R8", "outstanding expectations",
            XLEN'(sb.size()), '0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule